// File: doc/BRIEF.md
# Host command and status serial port

This block is the slave side of a three-wire serial link from a host microcontroller. The host frames a transfer by pulling the latch line low. It clocks in a command byte and, for write commands, a data byte. It ends the transfer by raising the latch. Write commands update the control registers that steer the buffered-audio datapath: a memory-control byte with a strobe, the direction and level of five general-purpose pins, mute, comparison width, memory type, error-check mode and compression select. Read commands return a status word, serially and in step with the host's shift clock.

The block also owns the sticky status flags. A jitter error flag is set by a selectable edge or level check of an error line against a frame clock. The overflow, buffer-overflow and decode-inhibit flags are set by event pulses from the datapath, and a completed status read clears them. An encode-inhibit flag follows any of the stop causes. An encode-running flag is set and cleared by commands and datapath conditions, and when both happen at once the clear wins. All host-side and flag-check inputs are asynchronous and pass through synchronizers, so every serial edge is found inside the block.

Top module: `host_cmd_port`

## Requirements
- R1: A transfer is the time the latch line is low. Data is taken on each rising edge of the shift clock, MSB first: 8 command bits, then 8 data bits. A write takes effect only when the latch rises after exactly 16 bits and the command is 80h, 81h, 82h, 83h or 85h. A shorter frame, or any other code such as 84h, changes no register.
- R2: For commands 90h to 93h the first status bit appears on the serial output after the falling shift-clock edge that follows the 8th rising edge. Each later falling edge presents the next bit, MSB first. The serial output is 0 while the latch is high.
- R3: Register 85h bits [3:0] select compression: bit0 gives code 0 (4-bit), bit1 gives code 1 (5-bit), bit2 gives code 2 (6-bit), bit3 gives code 3 (full). Any pattern with zero or several bits set gives code 2. Bits [5:4] are the error-check mode and bits [7:6] the memory type.
- R4: Register 81h bits [4:0] set pin directions (1 = output). Register 82h bits [4:0] set pin levels. A pin output shows its level only where the pin is an output and is 0 on inputs. Read 93h returns the synchronized pin inputs in bits [4:0].
- R5: Error-check mode 0 sets the error flag when the frame clock falls while the error line is low. Mode 1 does so on a rising frame clock with the line low, mode 2 while the line is low, and mode 3 while it is high.
- R6: Read 90h returns error (bit0), overflow-once (bit1), buffer overflow (bit2), encode inhibit (bit3) and decode inhibit (bit4). The rising latch that ends a 90h read clears bits 0, 1, 2 and 4 and leaves bit 3 alone. Event pulses set bits 1, 2 and 4, and any of error, overflow-once or buffer overflow sets bit 3.
- R7: Encode-running is set by an 80h write with bit0 (encode go) and bit7 (memory on) set, bits [5:4] zero, the error flag clear and the write-full input low. It is also set by a link-done pulse. It is cleared by an error set, by write-full high, or by an 80h write lacking encode go or memory on or with nonzero bits [5:4]. When a clear and a set coincide, the clear wins.
- R8: A write to 80h puts its byte on the memory-control output and pulses the strobe for one cycle. If bit2 or bit3 is set, the write clears status bits 1, 2, 3 and 4.
- R9: After reset every register and flag is 0 except the compression select, which resets to code 2. The serial output is 0.
- R10: Read 92h returns the 16-bit residual input, MSB first. Read 91h returns buffer-empty (bit0), write-full (bit1), encode-running (bit2) and decode-running (bit3).
- R11: Register 83h bit0 drives mute and bit1 selects the reduced comparison width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_dat_i | input | 1 | Host serial data |
| hs_clk_i | input | 1 | Host shift clock |
| hs_ld_i | input | 1 | Host latch; low frames a transfer |
| hs_out_o | output | 1 | Serial status output |
| frame_clk_i | input | 1 | Frame clock for the error check |
| jit_dat_i | input | 1 | Error line checked against the frame clock |
| ovf_once_evt_i | input | 1 | Overflow event pulse |
| buf_ovf_evt_i | input | 1 | Input-buffer overflow event pulse |
| resid_zero_evt_i | input | 1 | Residual-reached-zero event pulse |
| link_done_i | input | 1 | Reconnect-performed pulse |
| wr_full_i | input | 1 | Write-full level |
| buf_empty_i | input | 1 | No-valid-data level |
| dec_run_i | input | 1 | Decode-running level |
| resid_i | input | 16 | Valid data residual |
| gp_pin_i | input | 5 | Levels at the general-purpose pins |
| ms_ctrl_o | output | 8 | Memory-control byte |
| ms_stb_o | output | 1 | One-cycle strobe on memory-control write |
| enc_run_o | output | 1 | Encode-running flag |
| gp_oe_o | output | 5 | Pin output enables |
| gp_out_o | output | 5 | Pin output levels |
| mute_o | output | 1 | Forced mute |
| cmp12_o | output | 1 | Reduced-width comparison select |
| mem_type_o | output | 2 | Memory type code |
| comp_mode_o | output | 2 | Compression mode code |

## Verification
Compression select is driven with each single-bit pattern, with an empty pattern and with a two-bit pattern, so the one-hot decode can be told apart from a priority decode. The error check is run in all four modes. Each mode sees both the edge it reacts to and the edge or level it must ignore, so a wrong polarity or a swapped mode shows up in the next status read. Truncated frames and the unused 84h code show whether commit depends on the bit count and the code list. Back-to-back 90h reads, and reads after address-clear writes, separate the flags that a read clears from the encode-inhibit flag that survives it. Coincident set and clear pulses on encode-running show which one has priority.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
    localparam logic [7:0] CMD_MS  = 8'h80;
    localparam logic [7:0] CMD_DIR = 8'h81;
    localparam logic [7:0] CMD_LVL = 8'h82;
    localparam logic [7:0] CMD_AUD = 8'h83;
    localparam logic [7:0] CMD_OPT = 8'h85;
    localparam logic [7:0] CMD_ST0 = 8'h90;
    localparam logic [7:0] CMD_ST1 = 8'h91;
    localparam logic [7:0] CMD_RES = 8'h92;
    localparam logic [7:0] CMD_PIN = 8'h93;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 2 * BYTE_W;

    // memory-control byte fields
    localparam int MS_ENC_GO = 0;
    localparam int MS_DEC_GO = 1;
    localparam int MS_WA_CLR = 2;
    localparam int MS_RA_CLR = 3;
    localparam int MS_LINK0  = 4;
    localparam int MS_LINK1  = 5;
    localparam int MS_VWA    = 6;
    localparam int MS_MEM_ON = 7;

    localparam logic [7:0] OPT_RESET = 8'h04;

    typedef enum logic [1:0] {
        CM_4B   = 2'd0,
        CM_5B   = 2'd1,
        CM_6B   = 2'd2,
        CM_FULL = 2'd3
    } comp_mode_e;

    typedef enum logic [1:0] {
        JC_FALL_LOW   = 2'd0,
        JC_RISE_LOW   = 2'd1,
        JC_LEVEL_LOW  = 2'd2,
        JC_LEVEL_HIGH = 2'd3
    } jit_mode_e;

    function automatic logic is_write_cmd(input logic [7:0] c);
        return (c == CMD_MS) || (c == CMD_DIR) || (c == CMD_LVL) ||
               (c == CMD_AUD) || (c == CMD_OPT);
    endfunction

    function automatic logic is_read_cmd(input logic [7:0] c);
        return c[7:4] == 4'h9;
    endfunction
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hcp_serial.sv
module hcp_serial
    import hcp_pkg::*;
#(
    parameter int RD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdat_i,
    input  logic            ld_i,
    input  logic [RD_W-1:0] rd_word_i,
    output logic [7:0]      cmd_o,
    output logic [7:0]      dat_o,
    output logic            wr_stb_o,
    output logic            rd_clr_o,
    output logic            sout_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(BYTE_W);

    typedef struct packed {
        logic             sclk_p;
        logic             ld_p;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       cmd;
        logic [7:0]       dat;
        logic [RD_W-1:0]  sh;
        logic             loaded;
        logic             wr_stb;
        logic             rd_clr;
    } ser_t;

    ser_t q, d;
    logic rise, fall, ld_rise;

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        d.rd_clr = 1'b0;
        d.sclk_p = sclk_i;
        d.ld_p   = ld_i;
        rise     = sclk_i & ~q.sclk_p;
        fall     = ~sclk_i & q.sclk_p;
        ld_rise  = ld_i & ~q.ld_p;
        if (ld_i) begin
            if (ld_rise) begin
                if (q.cnt == CNT_FULL && is_write_cmd(q.cmd)) d.wr_stb = 1'b1;
                if (q.loaded && q.cmd == CMD_ST0)              d.rd_clr = 1'b1;
            end
            d.cnt    = '0;
            d.loaded = 1'b0;
            d.sh     = '0;
        end else begin
            if (rise && q.cnt < CNT_FULL) begin
                if (q.cnt < CNT_CMD) d.cmd = {q.cmd[6:0], sdat_i};
                else                 d.dat = {q.dat[6:0], sdat_i};
                d.cnt = q.cnt + 1'b1;
            end
            if (fall) begin
                if (q.loaded) begin
                    d.sh = q.sh << 1;
                end else if (q.cnt == CNT_CMD && is_read_cmd(q.cmd)) begin
                    d.sh     = rd_word_i;
                    d.loaded = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_o    = q.cmd;
    assign dat_o    = q.dat;
    assign wr_stb_o = q.wr_stb;
    assign rd_clr_o = q.rd_clr;
    assign sout_o   = q.loaded & q.sh[RD_W-1];

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> !sout_o) else $error("serial output active outside a frame");

    p_wr_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o) else $error("write strobe longer than one cycle");
endmodule

// File: rtl/hcp_regfile.sv
module hcp_regfile
    import hcp_pkg::*;
#(
    parameter int NPORT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic [7:0]       wr_cmd_i,
    input  logic [7:0]       wr_dat_i,
    output logic [7:0]       ms_o,
    output logic             ms_stb_o,
    output logic [NPORT-1:0] gp_oe_o,
    output logic [NPORT-1:0] gp_out_o,
    output logic             mute_o,
    output logic             cmp12_o,
    output logic [1:0]       mem_type_o,
    output logic [1:0]       jit_mode_o,
    output logic [1:0]       comp_mode_o
);
    typedef struct packed {
        logic [7:0]       ms;
        logic             ms_stb;
        logic [NPORT-1:0] oe;
        logic [NPORT-1:0] lv;
        logic             mute;
        logic             cmp12;
        logic [7:0]       opt;
    } reg_t;

    reg_t       q, d;
    comp_mode_e comp;

    always_comb begin
        d        = q;
        d.ms_stb = 1'b0;
        if (wr_stb_i) begin
            case (wr_cmd_i)
                CMD_MS:  begin d.ms = wr_dat_i; d.ms_stb = 1'b1; end
                CMD_DIR: d.oe = wr_dat_i[NPORT-1:0];
                CMD_LVL: d.lv = wr_dat_i[NPORT-1:0];
                CMD_AUD: begin d.mute = wr_dat_i[0]; d.cmp12 = wr_dat_i[1]; end
                CMD_OPT: d.opt = wr_dat_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (q.opt[3:0])
            4'b0001: comp = CM_4B;
            4'b0010: comp = CM_5B;
            4'b1000: comp = CM_FULL;
            default: comp = CM_6B;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.opt <= OPT_RESET;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_pin
        assign gp_out_o[i] = q.oe[i] & q.lv[i];
    end

    assign ms_o        = q.ms;
    assign ms_stb_o    = q.ms_stb;
    assign gp_oe_o     = q.oe;
    assign mute_o      = q.mute;
    assign cmp12_o     = q.cmp12;
    assign mem_type_o  = q.opt[7:6];
    assign jit_mode_o  = q.opt[5:4];
    assign comp_mode_o = comp;

    p_comp_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_mode_o != CM_6B) |-> ($countones(q.opt[3:0]) == 1))
        else $error("non-default compression from a non one-hot select");

    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable({q.ms, q.oe, q.lv, q.mute, q.cmp12, q.opt}))
        else $error("register changed without a committed write");
endmodule

// File: rtl/hcp_flags.sv
module hcp_flags
    import hcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fclk_i,
    input  logic       fdat_i,
    input  logic [1:0] jit_mode_i,
    input  logic       ms_stb_i,
    input  logic [7:0] ms_i,
    input  logic       rd_clr_i,
    input  logic       ovf1_evt_i,
    input  logic       bovf_evt_i,
    input  logic       rz_evt_i,
    input  logic       link_done_i,
    input  logic       wr_full_i,
    output logic [7:0] st0_o,
    output logic       enc_run_o
);
    typedef struct packed {
        logic fclk_p;
        logic err;
        logic ovf1;
        logic bovf;
        logic einh;
        logic dinh;
        logic run;
    } flag_t;

    flag_t q, d;
    logic  jit_hit, f_rise, f_fall, addr_clr, link_any, run_set, run_clr;

    always_comb begin
        d        = q;
        d.fclk_p = fclk_i;
        f_rise   = fclk_i & ~q.fclk_p;
        f_fall   = ~fclk_i & q.fclk_p;
        case (jit_mode_i)
            JC_FALL_LOW:  jit_hit = f_fall & ~fdat_i;
            JC_RISE_LOW:  jit_hit = f_rise & ~fdat_i;
            JC_LEVEL_LOW: jit_hit = ~fdat_i;
            default:      jit_hit = fdat_i;
        endcase
        addr_clr = ms_stb_i & (ms_i[MS_WA_CLR] | ms_i[MS_RA_CLR]);
        link_any = ms_i[MS_LINK0] | ms_i[MS_LINK1];

        d.err  = jit_hit    | (q.err  & ~rd_clr_i);
        d.ovf1 = ovf1_evt_i | (q.ovf1 & ~rd_clr_i & ~addr_clr);
        d.bovf = bovf_evt_i | (q.bovf & ~rd_clr_i & ~addr_clr);
        d.dinh = rz_evt_i   | (q.dinh & ~rd_clr_i & ~addr_clr);
        d.einh = (jit_hit | ovf1_evt_i | bovf_evt_i) |
                 (q.einh & ~link_done_i & ~addr_clr);

        run_set = (ms_stb_i & ms_i[MS_ENC_GO] & ms_i[MS_MEM_ON] & ~link_any &
                   ~q.err & ~wr_full_i) | link_done_i;
        run_clr = jit_hit | wr_full_i |
                  (ms_stb_i & (~ms_i[MS_ENC_GO] | ~ms_i[MS_MEM_ON] | link_any));
        if (run_clr)      d.run = 1'b0;
        else if (run_set) d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st0_o     = {3'b000, q.dinh, q.einh, q.bovf, q.ovf1, q.err};
    assign enc_run_o = q.run;

    p_level_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jit_mode_i == JC_LEVEL_HIGH && fdat_i) |=> q.err)
        else $error("level-high check missed an error");

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !ovf1_evt_i) |=> !q.ovf1)
        else $error("status read left overflow-once set");

    p_einh_survives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && q.einh && !link_done_i && !ms_stb_i) |=> q.einh)
        else $error("status read cleared encode inhibit");

    p_full_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full_i |=> !q.run)
        else $error("encode running while write-full");
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
    import hcp_pkg::*;
#(
    parameter int NPORT       = 5,
    parameter int RES_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_dat_i,
    input  logic             hs_clk_i,
    input  logic             hs_ld_i,
    output logic             hs_out_o,
    input  logic             frame_clk_i,
    input  logic             jit_dat_i,
    input  logic             ovf_once_evt_i,
    input  logic             buf_ovf_evt_i,
    input  logic             resid_zero_evt_i,
    input  logic             link_done_i,
    input  logic             wr_full_i,
    input  logic             buf_empty_i,
    input  logic             dec_run_i,
    input  logic [RES_W-1:0] resid_i,
    input  logic [NPORT-1:0] gp_pin_i,
    output logic [7:0]       ms_ctrl_o,
    output logic             ms_stb_o,
    output logic             enc_run_o,
    output logic [NPORT-1:0] gp_oe_o,
    output logic [NPORT-1:0] gp_out_o,
    output logic             mute_o,
    output logic             cmp12_o,
    output logic [1:0]       mem_type_o,
    output logic [1:0]       comp_mode_o
);
    localparam int RD_W   = RES_W;
    localparam int SYNC_W = 5 + NPORT;
    localparam int LOW_W  = RD_W - BYTE_W;

    logic [SYNC_W-1:0] async_in, sync_out;
    logic              s_dat, s_clk, s_ld, s_fclk, s_jit;
    logic [NPORT-1:0]  s_pin;
    logic [7:0]        cmd, dat, ms, st0, st1, pins;
    logic              wr_stb, rd_clr, ms_stb, enc_run;
    logic [1:0]        jit_mode;
    logic [RD_W-1:0]   rd_word;

    assign async_in = {gp_pin_i, jit_dat_i, frame_clk_i, hs_ld_i, hs_clk_i, hs_dat_i};

    hcp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(async_in), .q_o(sync_out)
    );
    assign {s_pin, s_jit, s_fclk, s_ld, s_clk, s_dat} = sync_out;

    assign st1  = {4'b0000, dec_run_i, enc_run, wr_full_i, buf_empty_i};
    assign pins = {{(BYTE_W-NPORT){1'b0}}, s_pin};

    always_comb begin
        case (cmd)
            CMD_ST0: rd_word = {st0, {LOW_W{1'b0}}};
            CMD_ST1: rd_word = {st1, {LOW_W{1'b0}}};
            CMD_RES: rd_word = resid_i;
            CMD_PIN: rd_word = {pins, {LOW_W{1'b0}}};
            default: rd_word = '0;
        endcase
    end

    hcp_serial #(.RD_W(RD_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .sclk_i(s_clk), .sdat_i(s_dat), .ld_i(s_ld),
        .rd_word_i(rd_word), .cmd_o(cmd), .dat_o(dat), .wr_stb_o(wr_stb),
        .rd_clr_o(rd_clr), .sout_o(hs_out_o)
    );

    hcp_regfile #(.NPORT(NPORT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_cmd_i(cmd), .wr_dat_i(dat),
        .ms_o(ms), .ms_stb_o(ms_stb), .gp_oe_o(gp_oe_o), .gp_out_o(gp_out_o),
        .mute_o(mute_o), .cmp12_o(cmp12_o), .mem_type_o(mem_type_o),
        .jit_mode_o(jit_mode), .comp_mode_o(comp_mode_o)
    );

    hcp_flags u_flags (
        .clk(clk), .rst_n(rst_n), .fclk_i(s_fclk), .fdat_i(s_jit), .jit_mode_i(jit_mode),
        .ms_stb_i(ms_stb), .ms_i(ms), .rd_clr_i(rd_clr), .ovf1_evt_i(ovf_once_evt_i),
        .bovf_evt_i(buf_ovf_evt_i), .rz_evt_i(resid_zero_evt_i), .link_done_i(link_done_i),
        .wr_full_i(wr_full_i), .st0_o(st0), .enc_run_o(enc_run)
    );

    assign ms_ctrl_o = ms;
    assign ms_stb_o  = ms_stb;
    assign enc_run_o = enc_run;
endmodule

// File: tb/host_cmd_port_tb.sv
`timescale 1ns/1ps
module host_cmd_port_tb;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_dat = 1'b0, hs_clk = 1'b0, hs_ld = 1'b1;
    logic frame_clk = 1'b0, jit_dat = 1'b1;
    logic ovf1_evt = 1'b0, bovf_evt = 1'b0, rz_evt = 1'b0, link_done = 1'b0;
    logic wr_full = 1'b0, buf_empty = 1'b0, dec_run = 1'b0;
    logic [15:0] resid = 16'hA5C3;
    logic [4:0]  gp_pin = 5'h00;
    logic        hs_out, ms_stb, enc_run, mute, cmp12;
    logic [7:0]  ms_ctrl;
    logic [4:0]  gp_oe, gp_out;
    logic [1:0]  mem_type, comp_mode;

    int n_vec = 0, n_bad = 0, stb_cnt = 0;
    bit done = 0;
    string       tag_q[$];
    logic [15:0] act_q[$], exp_q[$];

    always #2 clk = ~clk;

    host_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .hs_dat_i(hs_dat), .hs_clk_i(hs_clk), .hs_ld_i(hs_ld),
        .hs_out_o(hs_out), .frame_clk_i(frame_clk), .jit_dat_i(jit_dat),
        .ovf_once_evt_i(ovf1_evt), .buf_ovf_evt_i(bovf_evt), .resid_zero_evt_i(rz_evt),
        .link_done_i(link_done), .wr_full_i(wr_full), .buf_empty_i(buf_empty),
        .dec_run_i(dec_run), .resid_i(resid), .gp_pin_i(gp_pin), .ms_ctrl_o(ms_ctrl),
        .ms_stb_o(ms_stb), .enc_run_o(enc_run), .gp_oe_o(gp_oe), .gp_out_o(gp_out),
        .mute_o(mute), .cmp12_o(cmp12), .mem_type_o(mem_type), .comp_mode_o(comp_mode)
    );

    always @(posedge clk) if (ms_stb) stb_cnt <= stb_cnt + 1;

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0) begin
            string t;
            logic [15:0] a, e;
            t = tag_q.pop_front(); a = act_q.pop_front(); e = exp_q.pop_front();
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, a, e);
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tag_q.push_back(tag); act_q.push_back(act); exp_q.push_back(exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        hs_dat = b; wait_cyc(HALF);
        hs_clk = 1'b1; wait_cyc(HALF);
        hs_clk = 1'b0; wait_cyc(HALF);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic frame_start();
        hs_ld = 1'b0; wait_cyc(HALF);
    endtask

    task automatic frame_stop();
        hs_ld = 1'b1; wait_cyc(HALF + 4);
    endtask

    task automatic write_reg(input logic [7:0] c, input logic [7:0] v);
        frame_start(); send_bits({c, v}, 16); frame_stop();
    endtask

    task automatic read_reg(input string tag, input logic [7:0] c, input int nbits,
                            input logic [15:0] exp);
        logic [15:0] acc;
        acc = '0;
        frame_start();
        send_bits({8'h00, c}, 8);
        for (int i = 0; i < nbits; i++) begin
            acc = {acc[14:0], hs_out};
            hs_clk = 1'b1; wait_cyc(HALF);
            hs_clk = 1'b0; wait_cyc(HALF);
        end
        frame_stop();
        check(tag, acc, exp);
    endtask

    task automatic pulse_ev(input int which);
        @(negedge clk);
        case (which)
            0: ovf1_evt = 1'b1;
            1: bovf_evt = 1'b1;
            2: rz_evt = 1'b1;
            default: link_done = 1'b1;
        endcase
        @(negedge clk);
        ovf1_evt = 1'b0; bovf_evt = 1'b0; rz_evt = 1'b0; link_done = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int s0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        // R9 reset state
        check("R9 comp_mode", {14'd0, comp_mode}, 16'd2);
        check("R9 ports", {gp_oe, gp_out, mute, cmp12, mem_type, enc_run, hs_out}, 16'h0000);
        check("R9 ms_ctrl", {8'd0, ms_ctrl}, 16'h0000);
        read_reg("R9 R6 status0 after reset", 8'h90, 8, 16'h0000);

        // R4 pins
        write_reg(8'h81, 8'h13);
        write_reg(8'h82, 8'h1F);
        check("R4 oe", {11'd0, gp_oe}, 16'h0013);
        check("R4 out gated on inputs", {11'd0, gp_out}, 16'h0013);
        gp_pin = 5'h0A;
        read_reg("R4 pin read 93h", 8'h93, 8, 16'h000A);

        // R3 compression select
        write_reg(8'h85, 8'h01); check("R3 4-bit", {14'd0, comp_mode}, 16'd0);
        write_reg(8'h85, 8'h02); check("R3 5-bit", {14'd0, comp_mode}, 16'd1);
        write_reg(8'h85, 8'h08); check("R3 full", {14'd0, comp_mode}, 16'd3);
        write_reg(8'h85, 8'h03); check("R3 two bits fall back", {14'd0, comp_mode}, 16'd2);
        write_reg(8'h85, 8'h00); check("R3 empty falls back", {14'd0, comp_mode}, 16'd2);
        write_reg(8'h85, 8'hC1);
        check("R3 mem_type/comp", {12'd0, mem_type, comp_mode}, 16'h000C);

        // R11 mute / cmp12
        write_reg(8'h83, 8'h03);
        check("R11 mute cmp12", {14'd0, mute, cmp12}, 16'h0003);

        // R1 short frame and unused code
        frame_start(); send_bits(16'h085F, 12); frame_stop();
        write_reg(8'h84, 8'hFF);
        s0 = stb_cnt;
        write_reg(8'h86, 8'h00);
        check("R1 ignored frames", {mute, cmp12, mem_type, comp_mode, gp_oe, gp_out},
              {1'b1, 1'b1, 2'd3, 2'd0, 5'h13, 5'h13});
        check("R1 no strobe", 16'(stb_cnt - s0), 16'd0);

        // R8 / R7 memory-control and encode running
        s0 = stb_cnt;
        write_reg(8'h80, 8'h81);
        check("R8 ms_ctrl", {8'd0, ms_ctrl}, 16'h0081);
        check("R8 single strobe", 16'(stb_cnt - s0), 16'd1);
        check("R7 encode set", {15'd0, enc_run}, 16'd1);
        read_reg("R10 R7 status1", 8'h91, 8, 16'h0004);
        wr_full = 1'b1; wait_cyc(3); wr_full = 1'b0; wait_cyc(2);
        check("R7 write-full clears", {15'd0, enc_run}, 16'd0);
        write_reg(8'h80, 8'hB1);
        check("R7 link code blocks start", {15'd0, enc_run}, 16'd0);
        write_reg(8'h80, 8'h81);
        write_reg(8'h80, 8'h01);
        check("R7 memory off clears", {15'd0, enc_run}, 16'd0);
        @(negedge clk); wr_full = 1'b1; link_done = 1'b1;
        @(negedge clk); wr_full = 1'b0; link_done = 1'b0;
        wait_cyc(2);
        check("R7 clear wins over set", {15'd0, enc_run}, 16'd0);

        // R5 / R6 jitter check
        write_reg(8'h85, 8'h04);
        frame_clk = 1'b1; wait_cyc(8); frame_clk = 1'b0; wait_cyc(8);
        read_reg("R5 mode0 line high no error", 8'h90, 8, 16'h0000);
        jit_dat = 1'b0; wait_cyc(8);
        frame_clk = 1'b1; wait_cyc(8);
        read_reg("R5 mode0 ignores rise", 8'h90, 8, 16'h0000);
        frame_clk = 1'b0; wait_cyc(8);
        read_reg("R5 mode0 fall sets error", 8'h90, 8, 16'h0009);
        read_reg("R6 read cleared error, inhibit kept", 8'h90, 8, 16'h0008);
        write_reg(8'h85, 8'h14);
        frame_clk = 1'b1; wait_cyc(8);
        read_reg("R5 mode1 rise sets error", 8'h90, 8, 16'h0009);
        frame_clk = 1'b0; wait_cyc(8);
        read_reg("R5 mode1 ignores fall", 8'h90, 8, 16'h0008);
        jit_dat = 1'b1; wait_cyc(8);
        write_reg(8'h85, 8'h34);
        write_reg(8'h85, 8'h24);
        read_reg("R5 mode3 high sets error", 8'h90, 8, 16'h0009);
        read_reg("R5 mode2 high no error", 8'h90, 8, 16'h0008);
        jit_dat = 1'b0; wait_cyc(8); jit_dat = 1'b1; wait_cyc(8);
        read_reg("R5 mode2 low sets error", 8'h90, 8, 16'h0009);
        write_reg(8'h85, 8'h04);

        // R8 address clear and R6 event flags
        write_reg(8'h80, 8'h04);
        read_reg("R8 address clear drops inhibit", 8'h90, 8, 16'h0000);
        pulse_ev(0); pulse_ev(1); pulse_ev(2);
        read_reg("R6 event flags", 8'h90, 8, 16'h001E);
        read_reg("R6 read clears events", 8'h90, 8, 16'h0008);
        pulse_ev(0); pulse_ev(2);
        write_reg(8'h80, 8'h08);
        check("R8 ms_ctrl read-clear", {8'd0, ms_ctrl}, 16'h0008);
        read_reg("R8 read-address clear", 8'h90, 8, 16'h0000);

        // R10 residual and status1
        read_reg("R10 residual", 8'h92, 16, 16'hA5C3);
        buf_empty = 1'b1; dec_run = 1'b1;
        read_reg("R10 status1 levels", 8'h91, 8, 16'h0009);
        pulse_ev(3);
        check("R7 link done sets", {15'd0, enc_run}, 16'd1);
        check("R2 idle output", {15'd0, hs_out}, 16'd0);

        wait_cyc(5);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule